// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block screens one memory access per cycle against the attributes of the segment it targets. An access carries a kind (read, write or execute), an offset and a size. The segment supplies a base, a limit, a readable flag, a writable flag and a grows-downward flag. When protection is enabled and the core is not running a 64-bit code segment in long mode, the block raises a general-protection fault if the access kind is not permitted or if the byte range falls outside the valid region. The segment can be an ordinary segment or a grows-downward segment, and its limit may be numerically below its base.

The decision is registered: a request presented in one cycle produces its response on the next clock edge. When there is no fault, the offset is returned unchanged as the response address. Descriptor loading, privilege levels and paging are handled elsewhere.

Top module: `seg_guard_top`

## Requirements
- R1: `rsp_valid` equals `req_valid` from the previous clock cycle. Reset (active-low `rst_n`) clears `rsp_valid`, `gp_fault` and `rsp_addr` to zero.
- R2: Checks are active only when `prot_en`=1 and `long_act` and `cs_long` are not both 1. When checks are inactive, no request faults.
- R3: A write (`acc_kind`=2'b01) to a segment with `seg_wr_ok`=0 faults.
- R4: A read (`acc_kind`=2'b00, and also 2'b11) to a segment with `seg_rd_ok`=0 faults. An execute (`acc_kind`=2'b10) never faults on `seg_rd_ok` or on `seg_wr_ok`.
- R5: For an ordinary segment (`seg_grows_down`=0) with limit >= base, the access faults exactly when limit < offset+size.
- R6: For an ordinary segment with limit < base, the access faults exactly when both limit < offset+size and offset < base.
- R7: For a grows-downward segment (`seg_grows_down`=1) with limit < base, the access faults exactly when offset <= limit, or when offset+size >= base.
- R8: For a grows-downward segment with limit >= base, the access faults exactly when both offset <= limit and offset+size >= base.
- R9: offset+size is formed one bit wider than the address, so a sum that passes the top of the address space is compared at its true value and does not wrap.
- R10: `rsp_addr` equals the request offset when the response has no fault. It is zero when the response faults or when there was no request.
- R11: `gp_fault` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| acc_kind | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| acc_offset | input | ADDR_W | Offset of the first byte |
| acc_size | input | SIZE_W | Access size added to the offset |
| seg_rd_ok | input | 1 | Segment is readable |
| seg_wr_ok | input | 1 | Segment is writable |
| seg_grows_down | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| prot_en | input | 1 | Protection enabled |
| long_act | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is a 64-bit segment |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| gp_fault | output | 1 | General-protection fault for the response |
| rsp_addr | output | ADDR_W | Offset passed through when no fault |

## Verification
The bench sweeps every base, limit, offset and size of a 4-bit address, 2-bit size configuration for both segment directions. This covers the limit-below-base cases, where a design that ignores the wrap would fault ordinary accesses or pass forbidden ones. It also covers offsets near the top of the space, where a sum truncated to the address width would wrap to a small value and hide an overrun. Separate sweeps go over every access kind against every permission pair and over all eight mode combinations. A design that ran the readable check on execute accesses, or that bypassed on long mode alone without the code-segment flag, would give the wrong fault there. An idle cycle driven with faulting inputs catches a fault or address that leaks out without a request.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  typedef enum logic [1:0] {
    ACC_RD     = 2'b00,
    ACC_WR     = 2'b01,
    ACC_EX     = 2'b10,
    ACC_RD_ALT = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/seg_mode_gate.sv
module seg_mode_gate (
  input  logic prot_en,
  input  logic long_act,
  input  logic cs_long,
  output logic chk_on
);
  logic full_long;

  // 64-bit operation needs both the mode bit and a 64-bit code segment
  assign full_long = long_act & cs_long;
  assign chk_on    = prot_en & ~full_long;
endmodule

// File: rtl/seg_perm_check.sv
module seg_perm_check
  import seg_guard_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic       rd_ok,
  input  logic       wr_ok,
  output logic       wr_deny,
  output logic       rd_deny,
  output logic       perm_fault
);
  acc_kind_e kind;

  always_comb begin
    kind    = acc_kind_e'(acc_kind);
    wr_deny = 1'b0;
    rd_deny = 1'b0;
    unique case (kind)
      ACC_WR:             wr_deny = ~wr_ok;
      ACC_EX:             ; // fetches are not subject to the readable flag
      ACC_RD, ACC_RD_ALT: rd_deny = ~rd_ok;
      default:            ;
    endcase
  end

  assign perm_fault = wr_deny | rd_deny;
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              grows_down,
  output logic [ADDR_W:0]   acc_end,
  output logic              wrapped,
  output logic              bound_fault
);
  localparam int EW = ADDR_W + 1;

  // one extra bit keeps the carry of offset + size visible
  function automatic logic [EW-1:0] span_end(input logic [ADDR_W-1:0] off,
                                             input logic [SIZE_W-1:0] sz);
    return EW'(off) + EW'(sz);
  endfunction

  // ordinary segment: the valid region runs from base up to limit
  function automatic logic up_fault(input logic [ADDR_W-1:0] off,
                                    input logic [EW-1:0]     e,
                                    input logic [ADDR_W-1:0] b,
                                    input logic [ADDR_W-1:0] l,
                                    input logic              w);
    logic over;
    over = EW'(l) < e;
    return w ? (over && (off < b)) : over;
  endfunction

  // grows-downward segment: the valid region lies above the limit
  function automatic logic down_fault(input logic [ADDR_W-1:0] off,
                                      input logic [EW-1:0]     e,
                                      input logic [ADDR_W-1:0] b,
                                      input logic [ADDR_W-1:0] l,
                                      input logic              w);
    logic low_hit;
    logic high_hit;
    low_hit  = off <= l;
    high_hit = e >= EW'(b);
    return w ? (low_hit || high_hit) : (low_hit && high_hit);
  endfunction

  logic f_up;
  logic f_down;

  assign acc_end = span_end(offset, size);
  assign wrapped = limit < base;
  assign f_up    = up_fault(offset, acc_end, base, limit, wrapped);
  assign f_down  = down_fault(offset, acc_end, base, limit, wrapped);

  assign bound_fault = grows_down ? f_down : f_up;
endmodule

// File: rtl/seg_guard_top.sv
module seg_guard_top
  import seg_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_offset,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              seg_rd_ok,
  input  logic              seg_wr_ok,
  input  logic              seg_grows_down,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [ADDR_W-1:0] seg_limit,
  input  logic              prot_en,
  input  logic              long_act,
  input  logic              cs_long,
  output logic              rsp_valid,
  output logic              gp_fault,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic            chk_on;
  logic            wr_deny;
  logic            rd_deny;
  logic            perm_fault;
  logic [ADDR_W:0] acc_end;
  logic            wrapped;
  logic            bound_fault;
  logic            fault_now;

  seg_mode_gate u_mode (
    .prot_en  (prot_en),
    .long_act (long_act),
    .cs_long  (cs_long),
    .chk_on   (chk_on)
  );

  seg_perm_check u_perm (
    .acc_kind   (acc_kind),
    .rd_ok      (seg_rd_ok),
    .wr_ok      (seg_wr_ok),
    .wr_deny    (wr_deny),
    .rd_deny    (rd_deny),
    .perm_fault (perm_fault)
  );

  seg_bound_check #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_bound (
    .offset      (acc_offset),
    .size        (acc_size),
    .base        (seg_base),
    .limit       (seg_limit),
    .grows_down  (seg_grows_down),
    .acc_end     (acc_end),
    .wrapped     (wrapped),
    .bound_fault (bound_fault)
  );

  assign fault_now = chk_on & (perm_fault | bound_fault);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      gp_fault  <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      gp_fault  <= req_valid & fault_now;
      rsp_addr  <= (req_valid && !fault_now) ? acc_offset : '0;
    end
  end

  // ---------------- assertions ----------------
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> !gp_fault);
  assert_long_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && long_act && cs_long) |=> !gp_fault);
  assert_wr_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_on && acc_kind == ACC_WR && !seg_wr_ok) |=> gp_fault);
  assert_rd_deny_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && chk_on && acc_kind == ACC_RD && !seg_rd_ok) |=> gp_fault);
  assert_exec_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == ACC_EX && !bound_fault) |=> !gp_fault);
  assert_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !perm_fault && !seg_grows_down && !wrapped &&
     acc_end <= {1'b0, seg_limit}) |=> !gp_fault);
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> acc_end >= {1'b0, acc_offset});
  assert_fault_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> rsp_addr == '0);
  assert_fault_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> rsp_valid);
endmodule

// File: tb/tb_seg_guard_top.sv
module tb_seg_guard_top;
  localparam int AW = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    acc_kind = 2'b00;
  logic [AW-1:0] acc_offset = '0;
  logic [SW-1:0] acc_size = '0;
  logic          seg_rd_ok = 1'b1;
  logic          seg_wr_ok = 1'b1;
  logic          seg_grows_down = 1'b0;
  logic [AW-1:0] seg_base = '0;
  logic [AW-1:0] seg_limit = '1;
  logic          prot_en = 1'b1;
  logic          long_act = 1'b0;
  logic          cs_long = 1'b0;
  logic          rsp_valid;
  logic          gp_fault;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seg_guard_top #(.ADDR_W(AW), .SIZE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .acc_offset(acc_offset), .acc_size(acc_size), .seg_rd_ok(seg_rd_ok),
    .seg_wr_ok(seg_wr_ok), .seg_grows_down(seg_grows_down), .seg_base(seg_base),
    .seg_limit(seg_limit), .prot_en(prot_en), .long_act(long_act),
    .cs_long(cs_long), .rsp_valid(rsp_valid), .gp_fault(gp_fault),
    .rsp_addr(rsp_addr)
  );

  task automatic check(string tag, logic gv, logic ev, logic gf, logic ef,
                       logic [AW-1:0] ga, logic [AW-1:0] ea);
    checks++;
    if (gv !== ev || gf !== ef || ga !== ea) begin
      errors++;
      $display("FAIL %s: valid/fault/addr = %0b/%0b/%0d, expected %0b/%0b/%0d",
               tag, gv, gf, ga, ev, ef, ea);
    end
  endtask

  // drive one request at the falling edge, look after the next rising edge
  task automatic issue(input logic v);
    @(negedge clk);
    req_valid = v;
    @(posedge clk);
    #1;
  endtask

  // bound rule restated with plain integers
  function automatic bit model_bound(int off, int sz, int b, int l, bit down);
    int e;
    e = off + sz;
    if (!down) begin
      if (l >= b) return e > l;
      return (e > l) && (off < b);
    end
    if (l < b) return (off <= l) || (e >= b);
    return !((off > l) || (e < b));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", rsp_valid, 1'b0, gp_fault, 1'b0, rsp_addr, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive bound sweep, checks on, permissions open
    acc_kind = 2'b00;
    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 16; b++)
        for (int l = 0; l < 16; l++)
          for (int o = 0; o < 16; o++)
            for (int s = 0; s < 4; s++) begin
              bit ef;
              string tag;
              @(negedge clk);
              seg_grows_down = d[0];
              seg_base = AW'(b);
              seg_limit = AW'(l);
              acc_offset = AW'(o);
              acc_size = SW'(s);
              ef = model_bound(o, s, b, l, d[0]);
              if (o + s > 15 && d == 0 && l >= b) tag = "R9 carry";
              else if (d == 0) tag = (l >= b) ? "R5 ordinary" : "R6 ordinary-wrap";
              else tag = (l < b) ? "R7 down-wrap" : "R8 down";
              issue(1'b1);
              check(tag, rsp_valid, 1'b1, gp_fault, ef, rsp_addr,
                    ef ? AW'(0) : AW'(o));
            end

    // permission sweep with an in-range access
    seg_grows_down = 1'b0;
    seg_base = '0;
    seg_limit = '1;
    acc_offset = 4'd5;
    acc_size = '0;
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++) begin
        bit ef;
        @(negedge clk);
        acc_kind = 2'(k);
        seg_rd_ok = p[0];
        seg_wr_ok = p[1];
        ef = (k == 1) ? !p[1] : (k == 2) ? 1'b0 : !p[0];
        issue(1'b1);
        check((k == 1) ? "R3 write perm" : "R4 read/exec perm", rsp_valid, 1'b1,
              gp_fault, ef, rsp_addr, ef ? AW'(0) : 4'd5);
      end

    // mode sweep: a denied write only faults while checks are active
    acc_kind = 2'b01;
    seg_rd_ok = 1'b1;
    seg_wr_ok = 1'b0;
    for (int m = 0; m < 8; m++) begin
      bit ef;
      @(negedge clk);
      prot_en = m[0];
      long_act = m[1];
      cs_long = m[2];
      ef = m[0] && !(m[1] && m[2]);
      issue(1'b1);
      check("R2 mode gate", rsp_valid, 1'b1, gp_fault, ef, rsp_addr,
            ef ? AW'(0) : 4'd5);
    end

    // idle cycle with faulting inputs
    prot_en = 1'b1;
    long_act = 1'b0;
    cs_long = 1'b0;
    issue(1'b0);
    check("R11 idle no fault", rsp_valid, 1'b0, gp_fault, 1'b0, rsp_addr, '0);
    // request then idle: valid follows request by one cycle
    seg_wr_ok = 1'b1;
    issue(1'b1);
    check("R10 pass-through", rsp_valid, 1'b1, gp_fault, 1'b0, rsp_addr, 4'd5);
    issue(1'b0);
    check("R1 drop after idle", rsp_valid, 1'b0, gp_fault, 1'b0, rsp_addr, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule